// File: doc/BRIEF.md
# Brightness-Scaled Multi-Channel PWM Generator

This block turns a set of per-channel luminance codes into on/off enables for a bank of LED current sinks. Every channel shares one reference clock and one emission cycle of fixed length, 16384 clocks (1024 luminance steps of up to 16 clocks each). Within a cycle a channel is enabled for a number of clocks equal to its 10-bit luminance code multiplied by a global brightness multiplier. The multiplier runs from 1 to 16 and is selected by a 4-bit code that is shared by all channels. The brightness code therefore dims or brightens the whole array without touching any per-channel value.

A one-clock strobe starts emission. From then on, cycles follow each other back to back. The luminance and brightness inputs are captured at the start of every cycle, so the source can prepare the next frame while the current one is being emitted. A strobe that arrives in the middle of a cycle abandons that cycle and begins a fresh one at once. A pulse on the last clock of each complete cycle marks its end, so external row or colour switches can change at the boundary.

Top module: `led_pwm_array`

## Requirements
- R1: After reset, and until the first start strobe, all enables and the end pulse stay low.
- R2: Brightness code b selects a step multiplier of b+1: code 0000 gives 1, code 0111 gives 8, code 1111 gives 16.
- R3: In the clock after the edge that starts a cycle, every channel with a nonzero code turns on. It then stays on for exactly luminance × multiplier consecutive clocks and is off for the rest of the cycle.
- R4: A channel whose luminance code is 0 stays off for the whole cycle.
- R5: A cycle lasts exactly 16384 clocks whatever the codes are. Cycles repeat without a gap. The end pulse is high only on the last clock of each complete cycle.
- R6: Luminance and brightness inputs are sampled only at the edge that starts a cycle. Changes during a cycle have no effect until the next cycle starts.
- R7: A start strobe during a running cycle restarts timing from clock 0 with freshly sampled codes, and the truncated cycle produces no end pulse.
- R8: Each channel i takes its code from bits [10·i+9 : 10·i] of the luminance bus and is timed independently of the others.
- R9: Luminance 1023 at multiplier 16 gives 16368 on-clocks, followed by 16 off clocks before the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Start/restart strobe, sampled on the rising edge |
| lum_codes | input | 240 | 24 packed 10-bit luminance codes, channel 0 in the low bits |
| brt_code | input | 4 | Global brightness code, multiplier = code + 1 |
| pwm_en | output | 24 | Per-channel on enables |
| cyc_end | output | 1 | High on the last clock of each complete cycle |

## Verification
The situations hardest to reach from the ports are a saturated step index combined with a new cycle boundary, and a restart strobe that lands thousands of clocks into a cycle while the inputs are also being changed. The stimulus runs several whole cycles back to back. It changes every luminance code and the brightness code partway through each cycle, so the following cycle must pick them up exactly at the boundary. Near the end it fires a strobe about 5000 clocks into a cycle running at full brightness. A behavioural model, which works from products and cycle positions, is compared with all outputs on every clock. Per-cycle on-time totals are also checked for every channel.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

  localparam int LUM_W  = 10;
  localparam int BRT_W  = 4;
  localparam int CNT_W  = LUM_W + BRT_W;
  localparam int STEP_W = LUM_W + 1;

  typedef logic [LUM_W-1:0]  lum_t;
  typedef logic [BRT_W-1:0]  brt_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [CNT_W:0]    ontime_t;

  localparam cnt_t  CNT_LAST = '1;
  localparam step_t STEP_SAT = step_t'(1 << LUM_W);

  // step multiplier selected by a brightness code
  function automatic logic [BRT_W:0] mult_of(input brt_t b);
    return {1'b0, b} + (BRT_W+1)'(1);
  endfunction

  // number of enabled clocks a channel owes in one cycle
  function automatic ontime_t on_clocks(input lum_t l, input brt_t b);
    return ontime_t'(l) * ontime_t'(mult_of(b));
  endfunction

  // advance the luminance step index, holding once past the top code
  function automatic step_t step_next(input step_t s);
    return (s == STEP_SAT) ? STEP_SAT : s + step_t'(1);
  endfunction

endpackage

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer
  import led_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  brt_t  brt_q,
  output logic  running,
  output cnt_t  count,
  output step_t step,
  output logic  load,
  output logic  last
);

  brt_t pre;

  assign last = running && (count == CNT_LAST);
  assign load = start || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      step    <= '0;
      pre     <= '0;
    end else if (load) begin
      running <= 1'b1;
      count   <= '0;
      step    <= '0;
      pre     <= '0;
    end else if (running) begin
      count <= count + cnt_t'(1);
      if (pre == brt_q) begin
        pre  <= '0;
        step <= step_next(step);
      end else begin
        pre <= pre + brt_t'(1);
      end
    end
  end

  // R7: a strobe always lands on clock 0 of a fresh cycle
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && count == '0 && step == '0));

  // R5: a completed cycle wraps straight into the next
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> (running && count == '0));

  // R5: end pulse lasts one clock
  p_last_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last);

  // R9: step index never passes its saturation value
  p_step_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (step <= STEP_SAT));

  // R1: nothing starts without a strobe
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> !running);

endmodule

// File: rtl/pwm_code_latch.sv
module pwm_code_latch
  import led_pwm_pkg::*;
#(
  parameter int NCH = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NCH*LUM_W-1:0] lum_in,
  input  brt_t                 brt_in,
  output logic [NCH*LUM_W-1:0] lum_q,
  output brt_t                 brt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lum_q <= '0;
      brt_q <= '0;
    end else if (load) begin
      lum_q <= lum_in;
      brt_q <= brt_in;
    end
  end

  // R6: captured codes only move at a cycle boundary
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(lum_q) && $stable(brt_q)));

endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
  import led_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  running,
  input  logic  load,
  input  logic  last,
  input  step_t step,
  input  lum_t  lum,
  input  brt_t  brt,
  output logic  en
);

  assign en = running && (step < {1'b0, lum});

  // on-clock tally used by the on-time check
  ontime_t on_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   on_seen <= '0;
    else if (load) on_seen <= '0;
    else if (en)   on_seen <= on_seen + ontime_t'(1);
  end

  // R3: total on-time over a full cycle equals luminance x multiplier
  p_on_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> ((on_seen + ontime_t'(en)) == on_clocks(lum, brt)));

  // R3: once off inside a cycle, a channel stays off
  p_stay_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load && !en) |=> !en);

  // R4: zero code never lights
  p_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lum == '0) |-> !en);

endmodule

// File: rtl/led_pwm_array.sv
module led_pwm_array
  import led_pwm_pkg::*;
#(
  parameter int NCH = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_start,
  input  logic [NCH*LUM_W-1:0] lum_codes,
  input  logic [BRT_W-1:0]     brt_code,
  output logic [NCH-1:0]       pwm_en,
  output logic                 cyc_end
);

  localparam int BUS_W = NCH * LUM_W;

  logic             running;
  cnt_t             count;
  step_t            step;
  logic             load;
  logic             last;
  logic [BUS_W-1:0] lum_q;
  brt_t             brt_q;

  pwm_cycle_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cyc_start),
    .brt_q   (brt_q),
    .running (running),
    .count   (count),
    .step    (step),
    .load    (load),
    .last    (last)
  );

  pwm_code_latch #(.NCH(NCH)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .lum_in (lum_codes),
    .brt_in (brt_code),
    .lum_q  (lum_q),
    .brt_q  (brt_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan_cmp u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .running (running),
      .load    (load),
      .last    (last),
      .step    (step),
      .lum     (lum_q[i*LUM_W +: LUM_W]),
      .brt     (brt_q),
      .en      (pwm_en[i])
    );
  end

  assign cyc_end = last;

  // R1: an idle array is dark
  p_idle_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_en == '0 && !cyc_end));

  // R5: the end pulse only appears while a cycle runs
  p_end_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> running);

endmodule

// File: tb/sim_led_pwm_array.sv
module sim_led_pwm_array;

  localparam int NCH    = 24;
  localparam int PERIOD = 16384;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cyc_start = 1'b0;
  logic [NCH*10-1:0] lum_codes = '0;
  logic [3:0]      brt_code = '0;
  logic [NCH-1:0]  pwm_en;
  logic            cyc_end;

  led_pwm_array #(.NCH(NCH)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .lum_codes (lum_codes),
    .brt_code  (brt_code),
    .pwm_en    (pwm_en),
    .cyc_end   (cyc_end)
  );

  always #4 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  int    prints = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    lum_v [NCH];
  int    brt_v = 0;

  // behavioural reference: position in cycle and captured codes
  bit m_run = 0;
  int m_pos = 0;
  int m_lum [NCH];
  int m_brt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0;
      m_pos = 0;
    end else begin
      if (cyc_start || (m_run && m_pos == PERIOD-1)) begin
        m_run = 1;
        m_pos = 0;
        for (int i = 0; i < NCH; i++) m_lum[i] = int'(lum_codes[i*10 +: 10]);
        m_brt = int'(brt_code);
      end else if (m_run) begin
        m_pos = m_pos + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] exp_en;
      logic           exp_end;
      for (int i = 0; i < NCH; i++)
        exp_en[i] = m_run && (m_pos < m_lum[i] * (m_brt + 1));
      exp_end = m_run && (m_pos == PERIOD-1);
      vectors++;
      if (exp_en !== pwm_en || exp_end !== cyc_end) begin
        fails++;
        if (prints < 20) begin
          prints++;
          $display("FAIL %s pos=%0d actual en=%h end=%b expected en=%h end=%b",
                   cur_req, m_pos, pwm_en, cyc_end, exp_en, exp_end);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_codes();
    for (int i = 0; i < NCH; i++) lum_codes[i*10 +: 10] = 10'(lum_v[i]);
    brt_code = 4'(brt_v);
  endtask

  task automatic make_pattern(input int seed, input int b);
    for (int i = 0; i < NCH; i++) lum_v[i] = (i * seed + 3 * i * i + 17) % 1024;
    lum_v[0] = 0;
    lum_v[1] = 1;
    lum_v[2] = 1023;
    brt_v = b;
  endtask

  task automatic strobe();
    @(negedge clk);
    cyc_start = 1'b1;
    @(posedge clk);
    #1 cyc_start = 1'b0;
  endtask

  // observe one full cycle; optionally change codes partway through
  task automatic run_cycle(input int chg_at, input int seed, input int b);
    int on_cnt [NCH];
    int cap_lum [NCH];
    int cap_brt;
    int ends = 0;
    int end_pos = -1;
    cap_brt = 0;
    for (int i = 0; i < NCH; i++) on_cnt[i] = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      if (k == 0) begin
        for (int i = 0; i < NCH; i++) cap_lum[i] = lum_v[i];
        cap_brt = brt_v;
      end
      for (int i = 0; i < NCH; i++) if (pwm_en[i]) on_cnt[i]++;
      if (cyc_end) begin
        ends++;
        end_pos = k;
      end
      if (k == chg_at) begin
        make_pattern(seed, b);
        push_codes();
      end
    end
    chk("R5", ends, 1);
    chk("R5", end_pos, PERIOD-1);
    chk("R4", on_cnt[0], 0);
    chk("R2", on_cnt[1], cap_brt + 1);
    chk((cap_brt == 15) ? "R9" : "R3", on_cnt[2], cap_lum[2] * (cap_brt + 1));
    chk((chg_at >= 0) ? "R6" : "R3", on_cnt[3], cap_lum[3] * (cap_brt + 1));
    for (int i = 4; i < NCH; i++)
      chk("R8", on_cnt[i], cap_lum[i] * (cap_brt + 1));
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle until strobed, even with codes present
    make_pattern(97, 0);
    push_codes();
    repeat (20) @(negedge clk);
    chk("R1", int'(pwm_en), 0);
    chk("R1", int'(cyc_end), 0);

    // R3 / R2 at 1x, codes for the next cycle changed mid-way (R6)
    cur_req = "R3";
    strobe();
    run_cycle(4000, 131, 7);

    // R2 at 8x, change again mid-way
    cur_req = "R6";
    run_cycle(9000, 59, 15);

    // R9 at 16x, no change
    cur_req = "R9";
    run_cycle(-1, 0, 0);

    // R7: restart about 5000 clocks into a running cycle
    cur_req = "R7";
    repeat (5000) @(negedge clk);
    make_pattern(211, 3);
    push_codes();
    strobe();
    run_cycle(-1, 0, 0);

    finish_run();
  end

endmodule